// File: doc/BRIEF.md
# Format-Aware Cascadable Magnitude Comparator

This block compares two operands of parameterised width and raises exactly one of three outputs: less, equal or greater. A two-bit format select tells it how the operand bits are to be read: as unsigned binary, two's complement, one's complement or sign-magnitude. A plain bitwise compare puts every negative value above every positive one, because the sign bit carries the largest weight. The block corrects that in all three signed formats. In the two formats that have a second zero encoding, it also treats that encoding as equal to zero.

Three cascade inputs carry a result from a lower-order stage. This lets several blocks be chained for wider words. The cascade decides the outcome only when the two operands are equal in value. A cascade input that is not one-hot counts as "equal". The block is purely combinational.

Top module: `signcmp`

## Requirements
- R1: Exactly one of the outputs `lt`, `eq`, `gt` is 1 for every combination of inputs.
- R2: With `fmt` = 2'b00 the operands are unsigned, and the result follows plain binary magnitude.
- R3: With `fmt` = 2'b01 the operands are two's complement with the sign in bit W-1. Any operand with bit W-1 set compares below any operand with bit W-1 clear, and the result follows signed value.
- R4: With `fmt` = 2'b10 the operands are one's complement. A value with bit W-1 set is the negation of its bitwise inverse, and the result follows that signed value.
- R5: With `fmt` = 2'b10 the all-ones pattern has the same value as the all-zeros pattern.
- R6: With `fmt` = 2'b11 bit W-1 is the sign and bits W-2..0 are the magnitude. Signs are compared first. When both operands are negative, the larger magnitude is the smaller value.
- R7: With `fmt` = 2'b11 a pattern with the sign set and a zero magnitude has the same value as the all-zeros pattern.
- R8: When the two operands have equal value under the selected format and the cascade inputs are one-hot, the outputs equal the cascade inputs.
- R9: When the operands have equal value and the cascade inputs are not one-hot (none set, or two or more set), `eq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | W | First operand |
| opb | input | W | Second operand |
| fmt | input | 2 | Number format: 00 unsigned, 01 two's complement, 10 one's complement, 11 sign-magnitude |
| casc_lt | input | 1 | Lower-stage result: less |
| casc_eq | input | 1 | Lower-stage result: equal |
| casc_gt | input | 1 | Lower-stage result: greater |
| lt | output | 1 | opa is below opb |
| eq | output | 1 | opa equals opb (cascade-resolved) |
| gt | output | 1 | opa is above opb |

## Verification
Zero folding and the cascade hand-off act together when one operand is negative zero and the other is positive zero. In that case the outcome must come from the cascade inputs and not from the bit patterns. The bench drives these pairs in both operand orders. It tries every cascade pattern, including the ones that are not one-hot, and expects the outputs to copy or normalise the cascade. Random stimulus adds operand pairs with equal values, and the bench checks each result against a value model computed from the format rules.

// File: rtl/signcmp_pkg.sv
// Shared types for the format-aware comparator.
// Assumes a two-bit format select and a three-way relation bundle.
package signcmp_pkg;

    typedef enum logic [1:0] {
        FMT_UNS  = 2'b00,
        FMT_TWOS = 2'b01,
        FMT_ONES = 2'b10,
        FMT_SMAG = 2'b11
    } fmt_t;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
    } rel_t;

    localparam rel_t REL_EQ = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};

endpackage

// File: rtl/scmp_cascin.sv
// Cascade input conditioner.
// Passes a one-hot lower-stage relation through unchanged.
// Any other pattern collapses to "equal".
module scmp_cascin
    import signcmp_pkg::*;
(
    input  logic c_lt,
    input  logic c_eq,
    input  logic c_gt,
    output rel_t rel
);

    logic one_hot;

    // Detect a legal cascade pattern.
    always_comb begin
        one_hot = (c_lt ^ c_eq ^ c_gt) & ~(c_lt & c_eq & c_gt);
    end

    // Select passthrough or neutral equal.
    always_comb begin
        if (one_hot) begin
            rel = '{lt: c_lt, eq: c_eq, gt: c_gt};
        end else begin
            rel = REL_EQ;
        end
    end

endmodule

// File: rtl/scmp_keymap.sv
// Operand-to-key mapper.
// Folds negative zero onto zero, then rewrites the operand into an
// unsigned key whose binary order equals the value order of the format.
// Assumes W >= 2.
module scmp_keymap
    import signcmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  fmt_t         fmt,
    output logic [W-1:0] key
);

    localparam int MSB = W - 1;

    logic         neg_zero;
    logic [W-1:0] canon;

    // Recognise the second zero encoding of the selected format.
    always_comb begin
        unique case (fmt)
            FMT_ONES: neg_zero = &val;
            FMT_SMAG: neg_zero = val[MSB] & ~(|val[MSB-1:0]);
            default:  neg_zero = 1'b0;
        endcase
    end

    // Replace negative zero by the all-zeros pattern.
    always_comb begin
        canon = neg_zero ? '0 : val;
    end

    // Build an order-preserving unsigned key.
    always_comb begin
        unique case (fmt)
            FMT_UNS: key = canon;
            FMT_TWOS,
            FMT_ONES: key = {~canon[MSB], canon[MSB-1:0]};
            FMT_SMAG: key = canon[MSB] ? {1'b0, ~canon[MSB-1:0]}
                                       : {1'b1,  canon[MSB-1:0]};
            default:  key = canon;
        endcase
    end

endmodule

// File: rtl/scmp_slice.sv
// One-bit comparator slice.
// Decides the relation at its own bit when the bits differ.
// Otherwise it forwards the relation from the less significant side.
module scmp_slice
    import signcmp_pkg::*;
(
    input  logic a_bit,
    input  logic b_bit,
    input  rel_t below,
    output rel_t here
);

    // Local bit difference overrides lower-order result.
    always_comb begin
        if (a_bit & ~b_bit) begin
            here = '{lt: 1'b0, eq: 1'b0, gt: 1'b1};
        end else if (~a_bit & b_bit) begin
            here = '{lt: 1'b1, eq: 1'b0, gt: 1'b0};
        end else begin
            here = below;
        end
    end

endmodule

// File: rtl/signcmp.sv
// Format-aware cascadable magnitude comparator (top).
// Maps both operands to ordered keys and conditions the cascade.
// Then it runs a ripple of one-bit slices from bit 0 upward.
// Purely combinational. Assumes W >= 2.
module signcmp
    import signcmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [1:0]   fmt,
    input  logic         casc_lt,
    input  logic         casc_eq,
    input  logic         casc_gt,
    output logic         lt,
    output logic         eq,
    output logic         gt
);

    fmt_t         fmt_sel;
    logic [W-1:0] key_a;
    logic [W-1:0] key_b;
    rel_t         chain [W+1];

    // Interpret the raw format select.
    always_comb begin
        fmt_sel = fmt_t'(fmt);
    end

    scmp_cascin u_cin (
        .c_lt (casc_lt),
        .c_eq (casc_eq),
        .c_gt (casc_gt),
        .rel  (chain[0])
    );

    scmp_keymap #(.W(W)) u_key_a (
        .val (opa),
        .fmt (fmt_sel),
        .key (key_a)
    );

    scmp_keymap #(.W(W)) u_key_b (
        .val (opb),
        .fmt (fmt_sel),
        .key (key_b)
    );

    for (genvar i = 0; i < W; i++) begin : g_slice
        scmp_slice u_slice (
            .a_bit (key_a[i]),
            .b_bit (key_b[i]),
            .below (chain[i]),
            .here  (chain[i+1])
        );
    end

    // Drive the result from the most significant slice.
    always_comb begin
        lt = chain[W].lt;
        eq = chain[W].eq;
        gt = chain[W].gt;
    end

endmodule

// File: rtl/signcmp_chk.sv
// Property checker for signcmp, attached by bind.
// Watches ports only; combinational, so checks are immediate.
module signcmp_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic [1:0]   fmt,
    input logic         casc_lt,
    input logic         casc_eq,
    input logic         casc_gt,
    input logic         lt,
    input logic         eq,
    input logic         gt
);

    logic casc_ok;
    assign casc_ok = $onehot({casc_lt, casc_eq, casc_gt});

    // Check port relations whenever any input or output moves.
    always_comb begin
        AST_ONE_HOT: assert ($onehot({lt, eq, gt})) else $error("one-hot"); // R1
        AST_UNS_ORDER: assert (!(fmt == 2'b00 && opa > opb) || gt) else $error("uns"); // R2
        AST_TWOS_SIGN: assert (!(fmt == 2'b01 && opa[W-1] && !opb[W-1]) || lt) else $error("twos"); // R3
        AST_ONES_ZERO: assert (!(fmt == 2'b10 && (&opa) && opb == '0 && casc_ok) || ({lt, eq, gt} == {casc_lt, casc_eq, casc_gt})) else $error("ones zero"); // R5
        AST_SMAG_ZERO: assert (!(fmt == 2'b11 && opa == {1'b1, {(W-1){1'b0}}} && opb == '0 && casc_ok) || ({lt, eq, gt} == {casc_lt, casc_eq, casc_gt})) else $error("smag zero"); // R7
        AST_CASC_PASS: assert (!(opa == opb && casc_ok) || ({lt, eq, gt} == {casc_lt, casc_eq, casc_gt})) else $error("cascade"); // R8
        AST_CASC_BAD: assert (!(opa == opb && !casc_ok) || eq) else $error("bad cascade"); // R9
    end

endmodule

bind signcmp signcmp_chk #(.W(W)) u_chk (
    .opa     (opa),
    .opb     (opb),
    .fmt     (fmt),
    .casc_lt (casc_lt),
    .casc_eq (casc_eq),
    .casc_gt (casc_gt),
    .lt      (lt),
    .eq      (eq),
    .gt      (gt)
);

// File: tb/sim_signcmp.sv
// Self-checking bench for signcmp: directed corners plus seeded random.
module sim_signcmp;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [1:0]   fmt = 2'b00;
    logic         casc_lt = 1'b0;
    logic         casc_eq = 1'b1;
    logic         casc_gt = 1'b0;
    logic         lt;
    logic         eq;
    logic         gt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    signcmp #(.W(W)) u0 (
        .opa(opa), .opb(opb), .fmt(fmt),
        .casc_lt(casc_lt), .casc_eq(casc_eq), .casc_gt(casc_gt),
        .lt(lt), .eq(eq), .gt(gt)
    );

    // Signed value of a pattern under a format.
    function automatic int value_of(logic [W-1:0] x, logic [1:0] f);
        int v;
        logic [W-1:0] inv;
        inv = ~x;
        case (f)
            2'b00: v = int'(x);
            2'b01: v = x[W-1] ? int'(x) - (1 << W) : int'(x);
            2'b10: v = x[W-1] ? -int'(inv) : int'(x);
            default: v = x[W-1] ? -int'(x[W-2:0]) : int'(x[W-2:0]);
        endcase
        return v;
    endfunction

    // Expected {lt,eq,gt}.
    function automatic logic [2:0] model(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] f,
                                         logic [2:0] c);
        int va;
        int vb;
        va = value_of(a, f);
        vb = value_of(b, f);
        if (va < vb) return 3'b100;
        if (va > vb) return 3'b001;
        if (c == 3'b100 || c == 3'b010 || c == 3'b001) return c;
        return 3'b010;
    endfunction

    task automatic apply_check(string tag, logic [W-1:0] a, logic [W-1:0] b,
                               logic [1:0] f, logic [2:0] c);
        logic [2:0] exp_v;
        @(posedge clk);
        opa = a; opb = b; fmt = f;
        {casc_lt, casc_eq, casc_gt} = c;
        @(negedge clk);
        exp_v = model(a, b, f, c);
        checks++;
        if ({lt, eq, gt} !== exp_v) begin
            errors++;
            $display("FAIL %s: a=%h b=%h fmt=%b casc=%b actual=%b expected=%b",
                     tag, a, b, f, c, {lt, eq, gt}, exp_v);
        end
        if ($countones({lt, eq, gt}) != 1) begin
            errors++;
            $display("FAIL R1: actual=%b expected one-hot", {lt, eq, gt});
        end
    endtask

    initial begin
        logic [W-1:0] ra;
        logic [W-1:0] rb;
        logic [1:0]   rf;
        logic [2:0]   rc;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: zero operands, equal cascade.
        apply_check("R8 idle", 8'h00, 8'h00, 2'b00, 3'b010);
        // R2 unsigned order, top bit counts as weight.
        apply_check("R2", 8'h80, 8'h7f, 2'b00, 3'b010);
        apply_check("R2", 8'h01, 8'hff, 2'b00, 3'b001);
        // R3 two's complement.
        apply_check("R3", 8'h80, 8'h7f, 2'b01, 3'b010);
        apply_check("R3", 8'hff, 8'h00, 2'b01, 3'b001);
        apply_check("R3", 8'hfe, 8'hff, 2'b01, 3'b010);
        // R4 one's complement order.
        apply_check("R4", 8'hfe, 8'h00, 2'b10, 3'b010);
        apply_check("R4", 8'h80, 8'hfe, 2'b10, 3'b010);
        // R5 negative zero, both orders, every cascade.
        for (int c = 0; c < 8; c++) begin
            apply_check("R5", 8'hff, 8'h00, 2'b10, 3'(c));
            apply_check("R5", 8'h00, 8'hff, 2'b10, 3'(c));
        end
        // R6 sign-magnitude.
        apply_check("R6", 8'h85, 8'h83, 2'b11, 3'b010);
        apply_check("R6", 8'h81, 8'h00, 2'b11, 3'b001);
        apply_check("R6", 8'h05, 8'h03, 2'b11, 3'b100);
        // R7 sign-magnitude negative zero.
        for (int c = 0; c < 8; c++) begin
            apply_check("R7", 8'h80, 8'h00, 2'b11, 3'(c));
            apply_check("R7", 8'h00, 8'h80, 2'b11, 3'(c));
        end
        // R8 / R9 cascade behaviour on equal operands.
        apply_check("R8", 8'h5a, 8'h5a, 2'b01, 3'b100);
        apply_check("R8", 8'h5a, 8'h5a, 2'b11, 3'b001);
        apply_check("R9", 8'h33, 8'h33, 2'b00, 3'b000);
        apply_check("R9", 8'h33, 8'h33, 2'b10, 3'b111);
        apply_check("R9", 8'hc3, 8'hc3, 2'b01, 3'b101);
        // Random mix covering R2, R3, R4, R6 and R8.
        for (int n = 0; n < 4000; n++) begin
            ra = W'($urandom);
            rb = ($urandom % 4 == 0) ? ra : W'($urandom);
            rf = 2'($urandom);
            rc = 3'($urandom);
            apply_check("R2/R3/R4/R6/R8 random", ra, rb, rf, rc);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule